// File: doc/BRIEF.md
# Three-Wire Serial Gain Register Port

This block is the slave side of a three-wire configuration link for a variable-gain stage. A host holds an active-low select line low and clocks in a frame on a serial clock. The frame opens with a direction flag and a 4-bit address, then carries a 10-bit gain word. On a write the word collects in a shadow register and reaches the live gain output only when the select line returns high. On a read the block turns the data line around once the header is in. It then shifts the live gain value out, changing its output on falling clock edges so that the host can sample on rising edges.

The three link pins are treated as asynchronous to the system clock. Each passes through a two-flop synchronizer, and clock and select edges are found from the synchronized samples. A pin change therefore takes effect at the third system clock edge after it. The serial clock must be several times slower than the system clock. The bidirectional pad itself is outside the block: it receives the input level and supplies an output value with an output enable.

Top module: `gain_serial_port`

## Requirements
- R1: After reset the gain output is 0x096 and the data output enable is low.
- R2: While select is low, each rising serial clock edge takes one bit from the data line. Bit 0 of the frame is the direction flag (1 = read, 0 = write). Bits 1 to 4 are the address, least significant bit first. Bits 5 to 14 are the data word, least significant bit first. The block reacts at the third system clock edge after a pin changes.
- R3: A write to address GAIN_ADDR (default 3) that carries all 10 data bits copies the shifted word to the gain output on the rising edge of select. The gain output does not change while the bits are being shifted.
- R4: A write to any other address leaves the gain output unchanged.
- R5: A write in which select rises before all 10 data bits have arrived leaves the gain output unchanged.
- R6: Serial clock pulses after the 15th in one frame are ignored, so the data bits that follow do not change the committed word.
- R7: A read of address GAIN_ADDR raises the output enable at the 5th falling serial clock edge of the frame. At that edge it drives gain bit 0, and on each later falling edge it drives the next higher bit, through bit 9.
- R8: A read of any other address keeps the output enable low.
- R9: A high level on select drops the output enable and restarts the bit count, so an aborted frame does not disturb the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Level seen on the data pad |
| ld_n | input | 1 | Active-low frame select |
| sdio_out | output | 1 | Readback bit for the data pad |
| sdio_oe | output | 1 | Drive enable for the data pad |
| gain | output | 10 | Live gain value |

## Verification
The assertions check these properties on every cycle:
- The gain output moves only on a select rising edge, and only after a full write frame to the gain address.
- The bit count and shadow word freeze once 15 bits are in.
- The output enable is high only during a read of the gain address and falls while select is high.
- The readback bit changes only after a falling serial clock edge.

Only the bench scenarios can show the rest. These are the correct bit order and value of a committed word, the exact bit sequence read back after an earlier write, and that an aborted read leaves the next frame intact.

// File: rtl/gain_serial_port.sv
module gain_serial_port #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 10,
  parameter logic [ADDR_W-1:0] GAIN_ADDR = 4'h3,
  parameter logic [DATA_W-1:0] RESET_GAIN = 10'h096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdio_in,
  input  logic              ld_n,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic [DATA_W-1:0] gain
);
  localparam int HDR   = 1 + ADDR_W;
  localparam int FRAME = HDR + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);

  logic [2:0] sclk_q, ld_q;
  logic [1:0] sd_q;
  logic [CNT_W-1:0] cnt;
  logic rnw;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] shadow, rb;

  wire sclk_rise = sclk_q[1] & ~sclk_q[2];
  wire sclk_fall = ~sclk_q[1] & sclk_q[2];
  wire ld_s      = ld_q[1];
  wire ld_rise   = ld_q[1] & ~ld_q[2];
  wire sd_s      = sd_q[1];
  wire hit       = (addr == GAIN_ADDR);
  wire in_hdr    = (cnt >= CNT_W'(1)) && (cnt <= CNT_W'(ADDR_W));
  wire in_data   = (cnt >= CNT_W'(HDR)) && (cnt < CNT_W'(FRAME));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      ld_q   <= '1;
      sd_q   <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      ld_q   <= {ld_q[1:0], ld_n};
      sd_q   <= {sd_q[0], sdio_in};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt      <= '0;
      rnw      <= 1'b0;
      addr     <= '0;
      shadow   <= '0;
      rb       <= '0;
      sdio_out <= 1'b0;
      sdio_oe  <= 1'b0;
      gain     <= RESET_GAIN;
    end else begin
      if (ld_rise && !rnw && hit && cnt == CNT_W'(FRAME))
        gain <= shadow;
      if (ld_s) begin
        cnt     <= '0;
        sdio_oe <= 1'b0;
      end else if (sclk_rise && cnt < CNT_W'(FRAME)) begin
        cnt <= cnt + 1'b1;
        if (cnt == '0) rnw <= sd_s;
        if (in_hdr)    addr <= {sd_s, addr[ADDR_W-1:1]};
        if (in_data)   shadow <= {sd_s, shadow[DATA_W-1:1]};
      end else if (sclk_fall && rnw && hit && in_data) begin
        sdio_oe <= 1'b1;
        if (cnt == CNT_W'(HDR)) begin
          sdio_out <= gain[0];
          rb       <= gain >> 1;
        end else begin
          sdio_out <= rb[0];
          rb       <= rb >> 1;
        end
      end
    end
endmodule

// File: rtl/gain_serial_port_chk.sv
module gain_serial_port_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 10,
  parameter logic [ADDR_W-1:0] GAIN_ADDR = 4'h3,
  parameter int CNT_W = 4,
  parameter int FRAME = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_s,
  input logic              ld_rise,
  input logic              sclk_fall,
  input logic [CNT_W-1:0]  cnt,
  input logic              rnw,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] shadow,
  input logic [DATA_W-1:0] gain,
  input logic              sdio_oe,
  input logic              sdio_out
);
  AST_GAIN_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(gain) |-> $past(ld_rise)); // R3
  AST_GAIN_FULL_MATCH: assert property (@(posedge clk) disable iff (!rst_n) !$stable(gain) |-> $past(!rnw && addr == GAIN_ADDR && cnt == CNT_W'(FRAME))); // R5
  AST_FREEZE_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n) (!ld_s && cnt == CNT_W'(FRAME)) |=> (cnt == CNT_W'(FRAME) && $stable(shadow))); // R6
  AST_OE_ONLY_MATCHED_READ: assert property (@(posedge clk) disable iff (!rst_n) sdio_oe |-> (rnw && addr == GAIN_ADDR)); // R8
  AST_OE_DROP_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n) ld_s |=> !sdio_oe); // R9
  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sdio_out) |-> $past(sclk_fall)); // R7
endmodule

bind gain_serial_port gain_serial_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAIN_ADDR(GAIN_ADDR), .CNT_W(CNT_W), .FRAME(FRAME)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_s(ld_s), .ld_rise(ld_rise), .sclk_fall(sclk_fall),
  .cnt(cnt), .rnw(rnw), .addr(addr), .shadow(shadow), .gain(gain),
  .sdio_oe(sdio_oe), .sdio_out(sdio_out)
);

// File: tb/gain_serial_port_bench.sv
`timescale 1ns/1ps
module gain_serial_port_bench;
  localparam logic [3:0] A = 4'h3;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sdio_in = 1'b0, ld_n = 1'b1;
  logic sdio_out, sdio_oe;
  logic [9:0] gain;

  gain_serial_port u_gain_serial_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdio_in(sdio_in), .ld_n(ld_n),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .gain(gain)
  );

  always #4 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [9:0] ref_gain = 10'h096, exp_gain = 10'h096;
  logic exp_oe = 1'b0, exp_out = 1'b0;
  int nr = 0;
  logic f_rd = 1'b0;
  logic [3:0] f_addr = '0;
  logic [9:0] f_data = '0;

  task automatic tick();
    @(posedge clk);
    #2;
    compared++;
    if (gain !== exp_gain) begin
      mismatched++;
      $display("FAIL %s gain actual=%h expected=%h", cur_req, gain, exp_gain);
    end
    compared++;
    if (sdio_oe !== exp_oe) begin
      mismatched++;
      $display("FAIL %s oe actual=%b expected=%b", cur_req, sdio_oe, exp_oe);
    end
    if (exp_oe) begin
      compared++;
      if (sdio_out !== exp_out) begin
        mismatched++;
        $display("FAIL %s out actual=%b expected=%b", cur_req, sdio_out, exp_out);
      end
    end
  endtask

  task automatic wait2();
    tick(); tick();
  endtask

  task automatic pulse(input logic b);
    sdio_in = b; wait2(); tick();
    sclk = 1'b1; wait2();
    if (nr < 15) begin
      if (nr == 0) f_rd = b;
      else if (nr <= 4) f_addr[nr-1] = b;
      else f_data[nr-5] = b;
      nr++;
    end
    tick();
    sclk = 1'b0; wait2();
    if (f_rd && f_addr == A && nr >= 5) begin
      exp_oe = 1'b1;
      if (nr <= 14) exp_out = ref_gain[nr-5];
    end
    tick();
  endtask

  task automatic frame(input logic rd, input logic [3:0] ad, input logic [9:0] d, input int n);
    nr = 0; f_rd = 1'b0; f_addr = '0; f_data = '0;
    ld_n = 1'b0; wait2(); tick();
    for (int i = 0; i < n; i++) begin
      if (i == 0) pulse(rd);
      else if (i <= 4) pulse(ad[i-1]);
      else if (i <= 14) pulse(d[i-5]);
      else pulse(~d[(i - 15) % 10]);
    end
    ld_n = 1'b1; wait2();
    exp_oe = 1'b0;
    if (!f_rd && f_addr == A && nr == 15) ref_gain = f_data;
    exp_gain = ref_gain;
    tick();
    repeat (4) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R1"; repeat (4) tick();
    cur_req = "R3"; frame(1'b0, A, 10'h2A5, 15);
    cur_req = "R7"; frame(1'b1, A, 10'h000, 15);
    cur_req = "R4"; frame(1'b0, 4'h6, 10'h111, 15);
    cur_req = "R5"; frame(1'b0, A, 10'h155, 14);
    cur_req = "R6"; frame(1'b0, A, 10'h0F0, 19);
    cur_req = "R8"; frame(1'b1, 4'h9, 10'h000, 15);
    cur_req = "R9"; frame(1'b1, A, 10'h000, 8);
    cur_req = "R9"; frame(1'b0, A, 10'h36C, 15);
    cur_req = "R2"; frame(1'b1, A, 10'h000, 15);
    cur_req = "R2"; frame(1'b0, A, 10'h001, 15);
    cur_req = "R7"; frame(1'b1, A, 10'h000, 17);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule